// File: doc/BRIEF.md
# Streaming Write Mode Detector

This block sits beside a cache's write path and watches the write requests that enter it. It follows one stream of writes. If each write starts exactly where the previous one ended, the writes are contiguous and their byte total keeps growing. Two byte thresholds, each a whole number of cache lines, split that traffic into three modes:

- ALLOCATE: ordinary allocation.
- COALESCE: writes are coalesced, and lines are still allocated.
- NO_ALLOCATE: writes are coalesced, and whole-line writes skip allocation.

The cache reads two flags, coalesce and allocate, to decide how to treat a miss.

A second function decides whether a pending write miss to a given cache block should be held back for a while, so that more bytes of the line can arrive first. A small table holds one bounded countdown per block. A query for a block answers delay or no delay and counts that block down. A clear command drops the block's entry once its miss has been sent.

Top module: `wr_stream_mode`

## Requirements
- R1: After reset the mode is ALLOCATE (coalesce=0, allocate=1), the stream tracking is empty, every delay entry is invalid, and qRespValid=0.
- R2: coalesce is 1 in COALESCE and NO_ALLOCATE. allocate is 1 in ALLOCATE and COALESCE. A write sampled at a clock edge shows its effect on both flags right after that edge.
- R3: A write is contiguous when wrAddr equals the previous write's wrAddr plus its wrSize, modulo 2^ADDR_W. The first write after reset is never contiguous.
- R4: A contiguous write adds wrSize to the running byte count. It moves the mode to COALESCE when the new count is at least COAL_LINES*BLK_BYTES (128 by default). It moves the mode to NO_ALLOCATE when the new count is at least NOALLOC_LINES*BLK_BYTES (256 by default), and it may skip COALESCE to do so.
- R5: The running count saturates at the no-allocate threshold. Any number of further contiguous writes keeps the mode at NO_ALLOCATE, and the count never wraps.
- R6: A non-contiguous write sets the count to its own wrSize, restarts the expected address from itself, and sets the mode to ALLOCATE, whatever the size.
- R7: A query (qValid with block number qBlk) is answered the next cycle with qRespValid=1. qDelay=1 when the block's counter is above zero, and the counter then drops by one. Otherwise qDelay=0.
- R8: A query for an untracked block takes the lowest free entry, loads it with DELAY_INIT and applies R7 at once. With DELAY_INIT=3, repeated queries answer 1,1,1,0,0.
- R9: clrValid with block number clrBlk invalidates that block's entry. A later query for it reloads the counter as in R8.
- R10: When all DELAY_ENTRIES entries hold other blocks, a query for an untracked block answers qDelay=0 and adds no entry.
- R11: In a cycle without wrValid the mode flags keep their values.
- R12: When a query and a clear name the same block in one cycle, the answer comes from the table as it stood before that cycle, and the clear takes effect, so no entry for the block is left.
- R13: In a cycle after which no query was sampled, qRespValid=0 and qDelay=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrValid | input | 1 | A write request is present this cycle |
| wrAddr | input | ADDR_W | Start byte address of the write |
| wrSize | input | SIZE_W | Byte length of the write |
| qValid | input | 1 | Delay query strobe |
| qBlk | input | ADDR_W-log2(BLK_BYTES) | Block number queried |
| clrValid | input | 1 | Clear-delay strobe |
| clrBlk | input | ADDR_W-log2(BLK_BYTES) | Block number whose delay entry is dropped |
| coalesce | output | 1 | Mode is COALESCE or NO_ALLOCATE |
| allocate | output | 1 | Mode is ALLOCATE or COALESCE |
| qRespValid | output | 1 | A query answer is present |
| qDelay | output | 1 | The queried write miss should be held back |

## Verification
A query and a clear can name the same block in the same cycle. The bench provokes this on a block whose counter still stands at two. It expects the answer to be delay, taken from the table before that cycle. It then queries the block four more times and expects 1,1,1,0. That pattern only appears if the clear won and the counter was reloaded. If the countdown had won, the pattern would be 1,0,0,0. A write and a query are also issued together, and each result is judged on its own.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [1:0] {
    MODE_ALLOC   = 2'd0,
    MODE_COAL    = 2'd1,
    MODE_NOALLOC = 2'd2
  } wrMode_e;

  // strobes from the mode control to the stream datapath
  typedef struct packed {
    logic restart;     // open a new stream at this write
    logic accumulate;  // extend the current stream with this write
  } trackStrb_t;

endpackage

// File: rtl/swd_track_dp.sv
module swd_track_dp
  import swd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 8,
  parameter int CNT_W       = 10,
  parameter int COAL_THR    = 128,
  parameter int NOALLOC_THR = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SIZE_W-1:0] wrSize,
  input  trackStrb_t        strb,
  output logic              isContig,
  output logic              reachCoal,
  output logic              reachNoAlloc
);

  localparam logic [CNT_W-1:0] COAL_LIM    = CNT_W'(COAL_THR);
  localparam logic [CNT_W-1:0] NOALLOC_LIM = CNT_W'(NOALLOC_THR);

  logic [ADDR_W-1:0] expAddr;
  logic [CNT_W-1:0]  byteCnt;
  logic              streamLive;
  logic [CNT_W-1:0]  sumCnt;

  assign sumCnt       = byteCnt + CNT_W'(wrSize);
  assign isContig     = streamLive && (wrAddr == expAddr);
  assign reachCoal    = sumCnt >= COAL_LIM;
  assign reachNoAlloc = sumCnt >= NOALLOC_LIM;

  always_ff @(posedge clk) begin
    if (rst) begin
      expAddr    <= '0;
      byteCnt    <= '0;
      streamLive <= 1'b0;
    end else if (strb.restart) begin
      expAddr    <= wrAddr + ADDR_W'(wrSize);
      byteCnt    <= CNT_W'(wrSize);
      streamLive <= 1'b1;
    end else if (strb.accumulate) begin
      expAddr <= wrAddr + ADDR_W'(wrSize);
      byteCnt <= reachNoAlloc ? NOALLOC_LIM : sumCnt;
    end
  end

endmodule

// File: rtl/swd_mode_ctrl.sv
module swd_mode_ctrl
  import swd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrValid,
  input  logic       isContig,
  input  logic       reachCoal,
  input  logic       reachNoAlloc,
  output trackStrb_t strb,
  output logic       coalesce,
  output logic       allocate
);

  wrMode_e modeQ, modeD;

  always_comb begin
    strb.restart    = wrValid && !isContig;
    strb.accumulate = wrValid && isContig;
    modeD           = modeQ;
    if (strb.restart)
      modeD = MODE_ALLOC;
    else if (strb.accumulate) begin
      if (reachNoAlloc)   modeD = MODE_NOALLOC;
      else if (reachCoal) modeD = MODE_COAL;
      else                modeD = MODE_ALLOC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) modeQ <= MODE_ALLOC;
    else     modeQ <= modeD;
  end

  assign coalesce = (modeQ != MODE_ALLOC);
  assign allocate = (modeQ != MODE_NOALLOC);

endmodule

// File: rtl/swd_delay_tbl.sv
module swd_delay_tbl #(
  parameter int BLK_W      = 26,
  parameter int ENTRIES    = 4,
  parameter int DELAY_INIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qValid,
  input  logic [BLK_W-1:0] qBlk,
  input  logic             clrValid,
  input  logic [BLK_W-1:0] clrBlk,
  output logic             qRespValid,
  output logic             qDelay
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int DLY_W = $clog2(DELAY_INIT + 1);
  localparam logic [DLY_W-1:0] LOAD_VAL = DLY_W'(DELAY_INIT - 1);

  logic             entValid [ENTRIES];
  logic [BLK_W-1:0] entTag   [ENTRIES];
  logic [DLY_W-1:0] entCnt   [ENTRIES];

  logic             anyHit, anyFree, respDelay, sameClr;
  logic [IDX_W-1:0] hitIdx, freeIdx;

  always_comb begin
    anyHit  = 1'b0;
    anyFree = 1'b0;
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!anyHit && entValid[i] && entTag[i] == qBlk) begin
        anyHit = 1'b1;
        hitIdx = IDX_W'(i);
      end
      if (!anyFree && !entValid[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
    respDelay = anyHit ? (entCnt[hitIdx] != '0) : (anyFree && DELAY_INIT > 0);
    sameClr   = clrValid && (clrBlk == qBlk);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        entValid[i] <= 1'b0;
        entTag[i]   <= '0;
        entCnt[i]   <= '0;
      end
      qRespValid <= 1'b0;
      qDelay     <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (clrValid && entValid[i] && entTag[i] == clrBlk)
          entValid[i] <= 1'b0;
        else if (qValid && anyHit && hitIdx == IDX_W'(i) && entCnt[i] != '0)
          entCnt[i] <= entCnt[i] - 1'b1;
        else if (qValid && !anyHit && anyFree && freeIdx == IDX_W'(i) && !sameClr) begin
          entValid[i] <= 1'b1;
          entTag[i]   <= qBlk;
          entCnt[i]   <= LOAD_VAL;
        end
      end
      qRespValid <= qValid;
      qDelay     <= qValid && respDelay;
    end
  end

endmodule

// File: rtl/wr_stream_mode.sv
module wr_stream_mode
  import swd_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SIZE_W        = 8,
  parameter int BLK_BYTES     = 64,
  parameter int COAL_LINES    = 2,
  parameter int NOALLOC_LINES = 4,
  parameter int DELAY_INIT    = 3,
  parameter int DELAY_ENTRIES = 4,
  localparam int OFF_W        = $clog2(BLK_BYTES),
  localparam int BLK_W        = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic              qValid,
  input  logic [BLK_W-1:0]  qBlk,
  input  logic              clrValid,
  input  logic [BLK_W-1:0]  clrBlk,
  output logic              coalesce,
  output logic              allocate,
  output logic              qRespValid,
  output logic              qDelay
);

  localparam int COAL_THR    = COAL_LINES * BLK_BYTES;
  localparam int NOALLOC_THR = NOALLOC_LINES * BLK_BYTES;
  localparam int CNT_W       = $clog2(NOALLOC_THR + (1 << SIZE_W)) + 1;

  trackStrb_t strb;
  logic isContig, reachCoal, reachNoAlloc;

  swd_track_dp #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W),
    .COAL_THR(COAL_THR), .NOALLOC_THR(NOALLOC_THR)
  ) u_dp (
    .clk(clk), .rst(rst), .wrAddr(wrAddr), .wrSize(wrSize), .strb(strb),
    .isContig(isContig), .reachCoal(reachCoal), .reachNoAlloc(reachNoAlloc)
  );

  swd_mode_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrValid(wrValid), .isContig(isContig),
    .reachCoal(reachCoal), .reachNoAlloc(reachNoAlloc), .strb(strb),
    .coalesce(coalesce), .allocate(allocate)
  );

  swd_delay_tbl #(
    .BLK_W(BLK_W), .ENTRIES(DELAY_ENTRIES), .DELAY_INIT(DELAY_INIT)
  ) u_dly (
    .clk(clk), .rst(rst), .qValid(qValid), .qBlk(qBlk),
    .clrValid(clrValid), .clrBlk(clrBlk),
    .qRespValid(qRespValid), .qDelay(qDelay)
  );

endmodule

// File: rtl/wr_stream_mode_chk.sv
module wr_stream_mode_chk (
  input logic clk,
  input logic rst,
  input logic wrValid,
  input logic qValid,
  input logic coalesce,
  input logic allocate,
  input logic qRespValid,
  input logic qDelay
);

  // R1: reset leaves ALLOCATE and no answer
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (allocate && !coalesce && !qRespValid));

  // R2: at least one flag is always set
  a_r2_flag_pair: assert property (@(posedge clk) disable iff (rst)
    (coalesce || allocate));

  // R5/R6: a write in NO_ALLOCATE stays there or falls to ALLOCATE, never COALESCE
  a_r5_no_step_down: assert property (@(posedge clk) disable iff (rst)
    (wrValid && coalesce && !allocate) |=> !(coalesce && allocate));

  // R11: without a write the flags hold
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !wrValid |=> ($stable(coalesce) && $stable(allocate)));

  // R7: every query is answered the next cycle
  a_r7_answer_next: assert property (@(posedge clk) disable iff (rst)
    qValid |=> qRespValid);

  // R13: no query, no answer
  a_r13_quiet: assert property (@(posedge clk) disable iff (rst)
    !qValid |=> (!qRespValid && !qDelay));

endmodule

bind wr_stream_mode wr_stream_mode_chk u_chk (
  .clk(clk), .rst(rst), .wrValid(wrValid), .qValid(qValid),
  .coalesce(coalesce), .allocate(allocate),
  .qRespValid(qRespValid), .qDelay(qDelay)
);

// File: tb/wr_stream_mode_test.sv
`timescale 1ns/1ps
module wr_stream_mode_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrValid = 1'b0;
  logic [31:0] wrAddr = '0;
  logic [7:0]  wrSize = '0;
  logic        qValid = 1'b0;
  logic [25:0] qBlk = '0;
  logic        clrValid = 1'b0;
  logic [25:0] clrBlk = '0;
  logic        coalesce, allocate, qRespValid, qDelay;

  always #5 clk = ~clk;

  wr_stream_mode uut (
    .clk(clk), .rst(rst), .wrValid(wrValid), .wrAddr(wrAddr), .wrSize(wrSize),
    .qValid(qValid), .qBlk(qBlk), .clrValid(clrValid), .clrBlk(clrBlk),
    .coalesce(coalesce), .allocate(allocate),
    .qRespValid(qRespValid), .qDelay(qDelay)
  );

  // kind 0: mode (exp 0 ALLOCATE,1 COALESCE,2 NO_ALLOCATE); 1: answer with qDelay=exp; 2: no answer
  typedef struct {
    int    due;
    int    kind;
    int    exp;
    string tag;
  } item_t;

  item_t scb[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always begin
    @(posedge clk);
    #4;
    while (scb.size() > 0 && scb[0].due == cyc) begin
      item_t it;
      it = scb.pop_front();
      checks++;
      if (it.kind == 0) begin
        logic ec, ea;
        ec = (it.exp != 0);
        ea = (it.exp != 2);
        if (coalesce !== ec || allocate !== ea) begin
          fails++;
          $display("FAIL %s: coalesce/allocate=%b%b expected %b%b", it.tag, coalesce, allocate, ec, ea);
        end
      end else if (it.kind == 1) begin
        if (qRespValid !== 1'b1 || qDelay !== it.exp[0]) begin
          fails++;
          $display("FAIL %s: qRespValid/qDelay=%b%b expected 1%0d", it.tag, qRespValid, qDelay, it.exp);
        end
      end else begin
        if (qRespValid !== 1'b0 || qDelay !== 1'b0) begin
          fails++;
          $display("FAIL %s: qRespValid/qDelay=%b%b expected 00", it.tag, qRespValid, qDelay);
        end
      end
    end
  end

  // driver: one cycle of stimulus plus the expected results it should produce
  task automatic step(input logic doW, input logic [31:0] a, input logic [7:0] s,
                      input logic doQ, input logic [25:0] qb,
                      input logic doC, input logic [25:0] cb,
                      input int expMode, input int expD, input string tag);
    item_t it;
    @(posedge clk);
    #2;
    wrValid  = doW;  wrAddr = a;  wrSize = s;
    qValid   = doQ;  qBlk   = qb;
    clrValid = doC;  clrBlk = cb;
    if (expMode >= 0) begin
      it.due = cyc + 1; it.kind = 0; it.exp = expMode; it.tag = tag;
      scb.push_back(it);
    end
    if (expD >= 0) begin
      it.due = cyc + 1; it.kind = 1; it.exp = expD; it.tag = tag;
      scb.push_back(it);
    end else if (expD == -2) begin
      it.due = cyc + 1; it.kind = 2; it.exp = 0; it.tag = tag;
      scb.push_back(it);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [7:0] s, input int m, input string tag);
    step(1'b1, a, s, 1'b0, '0, 1'b0, '0, m, -1, tag);
  endtask

  task automatic qry(input logic [25:0] b, input int d, input string tag);
    step(1'b0, '0, '0, 1'b1, b, 1'b0, '0, -1, d, tag);
  endtask

  task automatic clr(input logic [25:0] b, input string tag);
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, b, -1, -2, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 0, -2, "R1 reset state");
    // R3/R4 stream build-up, 64-byte writes
    step(1'b1, 32'h1000, 8'd64, 1'b0, '0, 1'b0, '0, 0, -2, "R3 first write, R13 quiet");
    wr(32'h1040, 8'd64, 1, "R4 reach coalesce");
    wr(32'h1080, 8'd64, 1, "R2 coalesce flags");
    wr(32'h10C0, 8'd64, 2, "R4 reach no-allocate");
    for (int i = 0; i < 16; i++)
      wr(32'h1100 + 32'(i * 64), 8'd64, 2, "R5 saturation");
    repeat (3) step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 2, -1, "R11 hold");
    wr(32'h5000, 8'd64, 0, "R6 break");
    wr(32'h5040, 8'd32, 0, "R4 below threshold");
    wr(32'h5060, 8'd32, 1, "R4 equal coalesce threshold");
    wr(32'h5080, 8'd127, 1, "R4 one below no-allocate");
    wr(32'h50FF, 8'd1, 2, "R4 equal no-allocate threshold");
    wr(32'h9000, 8'd200, 0, "R6 large break");
    wr(32'h90C8, 8'd100, 2, "R4 skip to no-allocate");
    wr(32'h90C8, 8'd8, 0, "R3 repeat not contiguous");
    // delay table, DELAY_INIT=3, 4 entries
    qry(26'd5, 1, "R8 load");
    qry(26'd5, 1, "R7 count");
    qry(26'd5, 1, "R7 count");
    qry(26'd5, 0, "R7 exhausted");
    qry(26'd5, 0, "R7 stays zero");
    clr(26'd5, "R9 clear, R13 quiet");
    qry(26'd5, 1, "R9 reload");
    qry(26'd10, 1, "R8 second entry");
    qry(26'd11, 1, "R8 third entry");
    qry(26'd12, 1, "R8 fourth entry");
    qry(26'd13, 0, "R10 table full");
    qry(26'd13, 0, "R10 not added");
    clr(26'd10, "R9 clear frees slot");
    qry(26'd13, 1, "R10 freed slot used");
    step(1'b0, '0, '0, 1'b1, 26'd11, 1'b1, 26'd11, -1, 1, "R12 answer from prior state");
    qry(26'd11, 1, "R12 clear wins reload");
    qry(26'd11, 1, "R12 clear wins");
    qry(26'd11, 1, "R12 clear wins");
    qry(26'd11, 0, "R12 clear wins exhausted");
    step(1'b1, 32'hA000, 8'd64, 1'b1, 26'd12, 1'b0, '0, 0, 1, "R6 R7 write with query");
    step(1'b0, '0, '0, 1'b1, 26'd5, 1'b1, 26'd99, -1, 1, "R9 unrelated clear");
    step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 0, -2, "R13 idle");
    repeat (3) @(posedge clk);
    finish_run();
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

endmodule